// File: doc/BRIEF.md
# Two-Pass Conversion Stage Sequencer

This block steps an analog-to-digital conversion through its phases: a precharge phase, an acquisition phase and a conversion phase. Each phase has its own stage code. In two-pass mode the three phases run twice. The second pass yields a difference value, the second result minus the first. In one-pass mode the difference value is simply the result. Each difference is added into a signed running sum. On every update the block refreshes an overflow flag, an above-ceiling flag and a below-floor flag. It also sets a sticky update flag, which software clears with a strobe.

When two-pass mode is on and repeat mode is off, the sequencer parks between the two passes and waits for a fresh start pulse. While parked, the partial result is incomplete. For that reason a software clear of the update flag is refused during that time. With repeat mode on, the sequencer never parks and restarts on its own after each full cycle. The converter itself sits outside this block: its result arrives on a plain input, qualified by a valid strobe.

Top module: `adc_stage_seq`

## Requirements
- R1: After reset the stage code is 000 and the update, overflow, above and below flags, the difference value and the running sum are all zero.
- R2: A start pulse in stage 000 gives codes 001 (precharge), then 010 (acquisition), then 011 (conversion). Precharge lasts `pre_len` cycles and acquisition lasts `acq_len` cycles. Conversion holds until `res_vld` is high.
- R3: With two-pass on and repeat off, the end of conversion 011 leads to code 100. Code 100 holds until a start pulse. The second pass then runs 101, 110 and 111, and the block returns to 000.
- R4: With two-pass and repeat both on, code 011 goes straight to 101 with no 100. After 111 the sequence restarts at 001.
- R5: With one-pass and repeat on, the end of conversion 011 goes back to 001 without a start pulse. With repeat off it goes to 000.
- R6: The difference value `diff` is a signed `W+1`-bit value. In two-pass mode it is second result minus first result; in one-pass mode it is the result itself. Each update adds it, sign-extended, into the `AW`-bit signed sum `acc`.
- R7: On each update, `above` is 1 exactly when `diff > ceil_th`, and `below` is 1 exactly when `diff < floor_th`. Both comparisons are signed two's complement. Both flags hold their values between updates.
- R8: On each update, `ovf` is set to 1 if the signed addition into `acc` wraps, and to 0 otherwise. Hardware alone sets and clears it.
- R9: Each update sets `upd_flag`. The flag stays at 1 until a `upd_clr` pulse arrives while the stage code is not 100.
- R10: A `upd_clr` pulse while the stage code is 100 leaves `upd_flag` unchanged.
- R11: A start pulse in any stage other than 000 and 100 has no effect on the sequence.
- R12: A `pre_len` or `acq_len` of zero makes that phase last one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse; starts a cycle or resumes a parked one |
| two_pass | input | 1 | Two-pass mode enable |
| repeat_en | input | 1 | Repeat (free-running) mode enable |
| pre_len | input | CW | Precharge length in cycles |
| acq_len | input | CW | Acquisition length in cycles |
| res | input | W | Converter result |
| res_vld | input | 1 | Result valid strobe, ends a conversion phase |
| ceil_th | input | W+1 | Signed upper threshold |
| floor_th | input | W+1 | Signed lower threshold |
| upd_clr | input | 1 | Software clear strobe for the update flag |
| stage | output | 3 | Stage code |
| diff | output | W+1 | Latest signed difference value |
| acc | output | AW | Signed running sum |
| ovf | output | 1 | Sum overflow flag |
| above | output | 1 | Difference above upper threshold |
| below | output | 1 | Difference below lower threshold |
| upd_flag | output | 1 | Sticky update flag |

## Verification
The bench targets the following cases. It holds a start pulse through the first precharge, which catches a sequencer that restarts mid-cycle and shows up as extra 001 cycles. It pulses the software clear while the sequencer is parked, so a design that clears the update flag at code 100 drops the flag too early. It puts the difference value exactly on each threshold and one step past it, which exposes a non-strict or unsigned comparison. It drives the running sum across its positive limit and then adds zero, so an overflow flag that sticks, or that misses the wrap, is reported. Zero-length phases and both repeat modes finish the list: they catch codes that stall or a stray parked stage.

// File: rtl/adc_stage_seq.sv
module adc_stage_seq #(
  parameter int W  = 8,
  parameter int AW = 12,
  parameter int CW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 two_pass,
  input  logic                 repeat_en,
  input  logic [CW-1:0]        pre_len,
  input  logic [CW-1:0]        acq_len,
  input  logic [W-1:0]         res,
  input  logic                 res_vld,
  input  logic signed [W:0]    ceil_th,
  input  logic signed [W:0]    floor_th,
  input  logic                 upd_clr,
  output logic [2:0]           stage,
  output logic signed [W:0]    diff,
  output logic signed [AW-1:0] acc,
  output logic                 ovf,
  output logic                 above,
  output logic                 below,
  output logic                 upd_flag
);
  localparam int EW = W + 1;

  typedef enum logic [2:0] {
    S_IDLE = 3'b000, S_PRE1 = 3'b001, S_ACQ1 = 3'b010, S_CNV1 = 3'b011,
    S_PARK = 3'b100, S_PRE2 = 3'b101, S_ACQ2 = 3'b110, S_CNV2 = 3'b111
  } st_t;

  st_t st, nxt;
  logic [CW-1:0] cnt;
  logic [W-1:0]  first;
  logic          upd, wrap;
  logic signed [EW-1:0] d;
  logic signed [AW-1:0] ext, sum;

  assign stage = st;
  assign upd   = res_vld && ((st == S_CNV1 && !two_pass) || st == S_CNV2);
  assign d     = (st == S_CNV2) ? $signed({1'b0, res}) - $signed({1'b0, first})
                                : $signed({1'b0, res});
  assign ext   = {{(AW-EW){d[EW-1]}}, d};
  assign sum   = acc + ext;
  assign wrap  = (acc[AW-1] == ext[AW-1]) && (sum[AW-1] != acc[AW-1]);

  always_comb begin
    nxt = st;
    case (st)
      S_IDLE: if (start) nxt = S_PRE1;
      S_PRE1: if (cnt >= pre_len) nxt = S_ACQ1;
      S_ACQ1: if (cnt >= acq_len) nxt = S_CNV1;
      S_CNV1: if (res_vld) begin
        if (two_pass) nxt = repeat_en ? S_PRE2 : S_PARK;
        else          nxt = repeat_en ? S_PRE1 : S_IDLE;
      end
      S_PARK: if (start) nxt = S_PRE2;
      S_PRE2: if (cnt >= pre_len) nxt = S_ACQ2;
      S_ACQ2: if (cnt >= acq_len) nxt = S_CNV2;
      S_CNV2: if (res_vld) nxt = repeat_en ? S_PRE1 : S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      first <= '0;
    end else begin
      st  <= nxt;
      cnt <= (nxt != st) ? CW'(1) : cnt + 1'b1;
      if (st == S_CNV1 && res_vld) first <= res;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      diff     <= '0;
      acc      <= '0;
      ovf      <= 1'b0;
      above    <= 1'b0;
      below    <= 1'b0;
      upd_flag <= 1'b0;
    end else begin
      if (upd) begin
        diff     <= d;
        acc      <= sum;
        ovf      <= wrap;
        above    <= d > ceil_th;
        below    <= d < floor_th;
        upd_flag <= 1'b1;
      end else if (upd_clr && st != S_PARK) begin
        upd_flag <= 1'b0;
      end
    end
  end

  p_conv_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st inside {S_CNV1, S_CNV2}) && !res_vld |=> $stable(stage));

  p_park_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_CNV1 && res_vld && !(two_pass && !repeat_en) |=> stage != 3'b100);

  p_no_park_repeat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_CNV1 && repeat_en |=> stage != 3'b100);

  p_flags_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(above) && $stable(below) && $stable(ovf) && $stable(acc));

  p_upd_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> upd_flag);

  p_park_keeps_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_PARK && upd_flag |=> upd_flag);

  p_idle_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE |=> stage == 3'b000 || stage == 3'b001);
endmodule

// File: tb/tb_adc_stage_seq.sv
module tb_adc_stage_seq;
  logic clk = 0, rst_n = 0, start = 0, two_pass = 0, repeat_en = 0;
  logic [7:0] pre_len = 8'd3, acq_len = 8'd2, res = 0;
  logic res_vld = 0, upd_clr = 0;
  logic signed [8:0] ceil_th = 9'sd200, floor_th = -9'sd200;
  logic [2:0] stage;
  logic signed [8:0] diff;
  logic signed [11:0] acc;
  logic ovf, above, below, upd_flag;
  int checks = 0, errors = 0, acc_m = 0, ovf_m = 0;
  bit done = 0;

  always #5 clk = ~clk;

  adc_stage_seq #(.W(8), .AW(12), .CW(8)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .two_pass(two_pass), .repeat_en(repeat_en),
    .pre_len(pre_len), .acq_len(acq_len), .res(res), .res_vld(res_vld),
    .ceil_th(ceil_th), .floor_th(floor_th), .upd_clr(upd_clr), .stage(stage),
    .diff(diff), .acc(acc), .ovf(ovf), .above(above), .below(below), .upd_flag(upd_flag));

  task automatic tick; @(negedge clk); endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_stage(int code, int n, string tag);
    for (int i = 0; i < n; i++) begin chk(tag, stage, code); tick(); end
  endtask

  task automatic conv(int code, int val, string tag);
    chk(tag, stage, code); tick();
    chk({tag, " hold"}, stage, code);
    res = val[7:0]; res_vld = 1; tick(); res_vld = 0;
  endtask

  task automatic expect_update(int e, string tag);
    int s = acc_m + e;
    ovf_m = (s > 2047 || s < -2048);
    if (s > 2047) s -= 4096;
    if (s < -2048) s += 4096;
    acc_m = s;
    chk({tag, " R6 diff"}, int'(diff), e);
    chk({tag, " R6 acc"}, int'(acc), acc_m);
    chk({tag, " R8 ovf"}, ovf, ovf_m);
    chk({tag, " R7 above"}, above, int'(e > int'(ceil_th)));
    chk({tag, " R7 below"}, below, int'(e < int'(floor_th)));
    chk({tag, " R9 set"}, upd_flag, 1);
  endtask

  task automatic pulse_start; start = 1; tick(); start = 0; endtask

  task automatic do_single(int v, string tag);
    two_pass = 0; repeat_en = 0;
    pulse_start();
    run_stage(1, pre_len == 0 ? 1 : pre_len, {tag, " R2 pre"});
    run_stage(2, acq_len == 0 ? 1 : acq_len, {tag, " R2 acq"});
    conv(3, v, {tag, " R2 cnv"});
    chk({tag, " R5 idle"}, stage, 0);
    expect_update(v, tag);
  endtask

  task automatic do_double(int a, int b, string tag);
    two_pass = 1; repeat_en = 0;
    pulse_start();
    run_stage(1, pre_len, {tag, " R3 pre1"});
    run_stage(2, acq_len, {tag, " R3 acq1"});
    conv(3, a, {tag, " R3 cnv1"});
    run_stage(4, 2, {tag, " R3 park"});
    pulse_start();
    run_stage(5, pre_len, {tag, " R3 pre2"});
    run_stage(6, acq_len, {tag, " R3 acq2"});
    conv(7, b, {tag, " R3 cnv2"});
    chk({tag, " R3 idle"}, stage, 0);
    expect_update(b - a, tag);
  endtask

  task automatic t_reset;
    chk("R1 stage", stage, 0); chk("R1 acc", int'(acc), 0);
    chk("R1 diff", int'(diff), 0); chk("R1 flags", {ovf, above, below, upd_flag}, 0);
  endtask

  task automatic t_single;
    do_single(77, "single");
    upd_clr = 1; tick(); upd_clr = 0;
    chk("R9 clear idle", upd_flag, 0);
  endtask

  task automatic t_busy_start;
    two_pass = 0; repeat_en = 0;
    start = 1; tick();
    run_stage(1, 3, "R11 pre start held");
    start = 0;
    run_stage(2, 2, "R11 acq");
    conv(3, 5, "R11 cnv");
    chk("R11 idle", stage, 0);
    expect_update(5, "R11");
  endtask

  task automatic t_park_lock;
    two_pass = 1; repeat_en = 0;
    pulse_start();
    run_stage(1, 3, "R3 pre1"); run_stage(2, 2, "R3 acq1");
    conv(3, 40, "R3 cnv1");
    chk("R3 park", stage, 4);
    chk("R10 flag before", upd_flag, 1);
    upd_clr = 1; tick(); upd_clr = 0;
    chk("R10 clear ignored", upd_flag, 1);
    run_stage(4, 3, "R3 park wait");
    pulse_start();
    run_stage(5, 3, "R3 pre2"); run_stage(6, 2, "R3 acq2");
    conv(7, 100, "R3 cnv2");
    chk("R3 idle", stage, 0);
    expect_update(60, "R3");
    upd_clr = 1; tick(); upd_clr = 0;
    chk("R9 clear after park", upd_flag, 0);
  endtask

  task automatic t_thresh;
    ceil_th = 9'sd10; floor_th = -9'sd10;
    do_double(50, 60, "R7 eq ceil");
    do_double(50, 61, "R7 over ceil");
    do_double(50, 40, "R7 eq floor");
    do_double(50, 39, "R7 under floor");
    ceil_th = 9'sd200; floor_th = -9'sd200;
  endtask

  task automatic t_repeat_double;
    two_pass = 1; repeat_en = 1;
    pulse_start();
    run_stage(1, 3, "R4 pre1"); run_stage(2, 2, "R4 acq1");
    conv(3, 20, "R4 cnv1");
    chk("R4 no park", stage, 5);
    run_stage(5, 3, "R4 pre2"); run_stage(6, 2, "R4 acq2");
    conv(7, 25, "R4 cnv2");
    chk("R4 restart", stage, 1);
    expect_update(5, "R4");
    repeat_en = 0;
    run_stage(1, 3, "R4 pre1b"); run_stage(2, 2, "R4 acq1b");
    conv(3, 9, "R4 cnv1b");
    pulse_start();
    run_stage(5, 3, "R4 pre2b"); run_stage(6, 2, "R4 acq2b");
    conv(7, 8, "R4 cnv2b");
    chk("R4 idle", stage, 0);
    expect_update(-1, "R4b");
  endtask

  task automatic t_repeat_single;
    two_pass = 0; repeat_en = 1;
    pulse_start();
    run_stage(1, 3, "R5 pre"); run_stage(2, 2, "R5 acq");
    conv(3, 11, "R5 cnv");
    chk("R5 restart", stage, 1);
    expect_update(11, "R5");
    repeat_en = 0;
    run_stage(1, 3, "R5 pre b"); run_stage(2, 2, "R5 acq b");
    conv(3, 12, "R5 cnv b");
    chk("R5 idle", stage, 0);
    expect_update(12, "R5b");
  endtask

  task automatic t_overflow;
    for (int i = 0; i < 24 && !ovf_m; i++) do_single(255, "R8 fill");
    chk("R8 wrap seen", ovf, 1);
    do_single(0, "R8 clear");
    chk("R8 cleared", ovf, 0);
  endtask

  task automatic t_zero_len;
    pre_len = 0; acq_len = 0;
    do_single(3, "R12 zero");
    pre_len = 8'd3; acq_len = 8'd2;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1; tick();
    t_reset();
    t_single();
    t_busy_start();
    t_park_lock();
    t_thresh();
    t_repeat_double();
    t_repeat_single();
    t_zero_len();
    t_overflow();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule